// File: doc/BRIEF.md
# BCD Seven-Segment Hold Decoder

This block turns a 4-bit BCD digit into seven active-high segment drives for a numeric display. A hold input decides whether the digit is taken from the input or kept from an earlier cycle. While hold is low, the block captures the input digit on every clock. While hold is high, it keeps showing the last digit it captured. Because the block runs on a single clock, a small register takes the place of a transparent latch.

Two active-low controls act on the output stage only. The lamp-test input lights every segment, so a user can check the display. The blank input turns every segment off. A user can pulse the blank input to dim the display or to share one display bus between several digits. Lamp test wins over blank, and blank wins over the decoded digit. Neither control disturbs the stored digit. Input codes above nine give a dark display.

Top module: `seg7_hold_decoder`

## Requirements
- R1: While `lamp_test_n` is 0, `seg` is 7'h7F one clock later, whatever the values of `blank_n`, `hold` and `bcd_in`.
- R2: While `lamp_test_n` is 1 and `blank_n` is 0, `seg` is 7'h00 one clock later, whatever the values of `hold` and `bcd_in`.
- R3: On each rising edge where `hold` is 0, the block stores `bcd_in`. While `hold` is 1, the stored code does not change, and the display keeps showing it when `bcd_in` changes.
- R4: With both controls inactive, codes 10 to 15 (4'hA to 4'hF) give `seg` = 7'h00.
- R5: Digit 6 gives 7'h7C (segments c, d, e, f, g; segment a is off). Digit 9 gives 7'h67 (segments a, b, c, f, g; segment d is off).
- R6: The bus order is {g,f,e,d,c,b,a}, with a at bit 0. The other digits give: 0 = 7'h3F, 1 = 7'h06, 2 = 7'h5B, 3 = 7'h4F, 4 = 7'h66, 5 = 7'h6D, 7 = 7'h07, 8 = 7'h7F.
- R7: Lamp test and blank leave the stored code unchanged. When both controls return high while `hold` is 1, the stored digit shows again.
- R8: A synchronous reset (`rst` high at a rising edge) clears the stored code to 0 and drives `seg` to 7'h00.
- R9: `seg` is registered, so a change on any input appears at `seg` exactly one rising edge later and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bcd_in | input | 4 | BCD digit to display |
| hold | input | 1 | 0: capture `bcd_in`; 1: keep the stored digit |
| lamp_test_n | input | 1 | Active-low lamp test; lights all segments |
| blank_n | input | 1 | Active-low blank; turns all segments off |
| seg | output | 7 | Segment drives {g,f,e,d,c,b,a}, active high |

## Verification
The bench covers the decoder in four ways, and each tells a different kind of fault apart:
- **All 16 codes with hold low.** This separates every glyph from its neighbours, including the tail-less 6 and 9 and the dark codes above nine.
- **Both overrides with an illegal code and then with a lit digit.** This separates the lamp-test over blank priority from the plain decode.
- **A held digit under a changing input, with each override pulsed.** This shows whether the stored code survives, not just whether the current input decodes correctly.
- **Samples just before and just after an edge.** These pin the one-clock latency, and a reset taken while hold is high shows that the stored code really returns to zero.

// File: rtl/seg7_hold_decoder.sv
module seg7_hold_decoder #(
  parameter int CODE_W = 4,
  parameter int SEG_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] bcd_in,
  input  logic              hold,
  input  logic              lamp_test_n,
  input  logic              blank_n,
  output logic [SEG_W-1:0]  seg
);

  localparam logic [SEG_W-1:0] ALL_ON  = '1;
  localparam logic [SEG_W-1:0] ALL_OFF = '0;

  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] code_sel;
  logic [SEG_W-1:0]  glyph;
  logic [SEG_W-1:0]  seg_d;
  logic [SEG_W-1:0]  seg_q;

  assign code_sel = hold ? code_q : bcd_in;

  always_comb begin
    unique case (code_sel)
      4'd0:    glyph = 7'h3F;
      4'd1:    glyph = 7'h06;
      4'd2:    glyph = 7'h5B;
      4'd3:    glyph = 7'h4F;
      4'd4:    glyph = 7'h66;
      4'd5:    glyph = 7'h6D;
      4'd6:    glyph = 7'h7C;
      4'd7:    glyph = 7'h07;
      4'd8:    glyph = 7'h7F;
      4'd9:    glyph = 7'h67;
      default: glyph = ALL_OFF;
    endcase
  end

  assign seg_d = !lamp_test_n ? ALL_ON :
                 !blank_n     ? ALL_OFF : glyph;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      seg_q  <= ALL_OFF;
    end else begin
      if (!hold) code_q <= bcd_in;
      seg_q <= seg_d;
    end
  end

  assign seg = seg_q;

endmodule

// File: rtl/seg7_hold_decoder_chk.sv
module seg7_hold_decoder_chk (
  input logic       clk,
  input logic       rst,
  input logic [3:0] bcd_in,
  input logic       hold,
  input logic       lamp_test_n,
  input logic       blank_n,
  input logic [3:0] code_q,
  input logic [6:0] seg
);

  p_lamp_all_on_r1: assert property (@(posedge clk) disable iff (rst)
    !lamp_test_n |=> seg == 7'h7F);

  p_blank_all_off_r2: assert property (@(posedge clk) disable iff (rst)
    (lamp_test_n && !blank_n) |=> seg == 7'h00);

  p_hold_keeps_code_r3: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(code_q));

  p_capture_code_r3: assert property (@(posedge clk) disable iff (rst)
    !hold |=> code_q == $past(bcd_in));

  p_illegal_dark_r4: assert property (@(posedge clk) disable iff (rst)
    (lamp_test_n && blank_n && !hold && bcd_in > 4'd9) |=> seg == 7'h00);

  p_override_keeps_code_r7: assert property (@(posedge clk) disable iff (rst)
    (hold && (!lamp_test_n || !blank_n)) |=> code_q == $past(code_q));

  p_reset_clears_r8: assert property (@(posedge clk)
    rst |=> (code_q == 4'd0 && seg == 7'h00));

endmodule

bind seg7_hold_decoder seg7_hold_decoder_chk u_chk (
  .clk(clk), .rst(rst), .bcd_in(bcd_in), .hold(hold),
  .lamp_test_n(lamp_test_n), .blank_n(blank_n), .code_q(code_q), .seg(seg)
);

// File: tb/test_seg7_hold_decoder.sv
module test_seg7_hold_decoder;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] bcd_in = 4'd0;
  logic       hold = 1'b0;
  logic       lamp_test_n = 1'b1;
  logic       blank_n = 1'b1;
  logic [6:0] seg;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  seg7_hold_decoder i_seg7_hold_decoder (
    .clk(clk), .rst(rst), .bcd_in(bcd_in), .hold(hold),
    .lamp_test_n(lamp_test_n), .blank_n(blank_n), .seg(seg)
  );

  // {lamp_test_n, blank_n, hold, bcd[3:0], expected seg[6:0]}
  localparam int NV = 19;
  localparam logic [13:0] VEC [0:NV-1] = '{
    {3'b110, 4'd0,  7'h3F},  // R6
    {3'b110, 4'd1,  7'h06},  // R6
    {3'b110, 4'd2,  7'h5B},  // R6
    {3'b110, 4'd3,  7'h4F},  // R6
    {3'b110, 4'd4,  7'h66},  // R6
    {3'b110, 4'd5,  7'h6D},  // R6
    {3'b110, 4'd6,  7'h7C},  // R5
    {3'b110, 4'd7,  7'h07},  // R6
    {3'b110, 4'd8,  7'h7F},  // R6
    {3'b110, 4'd9,  7'h67},  // R5
    {3'b110, 4'd10, 7'h00},  // R4
    {3'b110, 4'd11, 7'h00},  // R4
    {3'b110, 4'd12, 7'h00},  // R4
    {3'b110, 4'd13, 7'h00},  // R4
    {3'b110, 4'd14, 7'h00},  // R4
    {3'b110, 4'd15, 7'h00},  // R4
    {3'b000, 4'd12, 7'h7F},  // R1
    {3'b011, 4'd5,  7'h7F},  // R1
    {3'b100, 4'd8,  7'h00}   // R2
  };

  task automatic check(input logic [6:0] exp, input string req);
    n_chk++;
    if (seg !== exp) begin
      n_bad++;
      $display("FAIL %s: seg=%h expected %h", req, seg, exp);
    end
  endtask

  task automatic drive(input logic lt, input logic bl, input logic h, input logic [3:0] d);
    @(negedge clk);
    lamp_test_n = lt; blank_n = bl; hold = h; bcd_in = d;
    @(posedge clk);
    #1;
  endtask

  initial begin
    @(posedge clk); @(posedge clk); #1;
    check(7'h00, "R8 reset output");
    @(negedge clk); rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][13], VEC[i][12], VEC[i][11], VEC[i][10:7]);
      check(VEC[i][6:0], $sformatf("R4/R5/R6/R1/R2 vector %0d", i));
    end

    // R3: capture 3, then hold while input changes
    drive(1, 1, 0, 4'd3);
    check(7'h4F, "R3 capture");
    drive(1, 1, 1, 4'd8);
    check(7'h4F, "R3 held under new input");
    drive(1, 1, 1, 4'd1);
    check(7'h4F, "R3 held second change");

    // R7: overrides while held leave the stored digit
    drive(0, 1, 1, 4'd1);
    check(7'h7F, "R7 lamp test while held");
    drive(1, 1, 1, 4'd1);
    check(7'h4F, "R7 digit back after lamp test");
    drive(1, 0, 1, 4'd1);
    check(7'h00, "R7 blank while held");
    drive(1, 1, 1, 4'd1);
    check(7'h4F, "R7 digit back after blank");

    // R9: latency
    @(negedge clk); hold = 1'b0; bcd_in = 4'd7;
    #3; check(7'h4F, "R9 before edge");
    @(posedge clk); #1;
    check(7'h07, "R9 after edge");

    // R8: reset clears held code
    drive(1, 1, 0, 4'd9);
    check(7'h67, "R8 setup");
    @(negedge clk); hold = 1'b1; rst = 1'b1;
    @(posedge clk); #1;
    check(7'h00, "R8 reset while held");
    drive(1, 1, 1, 4'd5);
    check(7'h00, "R8 output cleared after reset edge");
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    check(7'h3F, "R8 stored code is zero");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run hung, actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule